// File: doc/BRIEF.md
# Serial Frame Sync Word Detector

This block watches a demodulated serial bit stream for a synchronization word. It takes a bit on every rising edge of the recovered receive clock. The word is one of two 16-bit frame words. When bit-sync is selected, the word also carries a 4-bit alternating preamble ahead of it. On a match the block raises a sticky frame-detect flag.

While detection is enabled and no word has been found yet, the block holds the outgoing data and clock lines high. Downstream logic therefore sees an idle line until sync is acquired. After that, both lines follow the receive stream. With detection disabled, both lines pass straight through and the flag stays low. A full power-down (power-down request with receive enable low) clears the flag.

The receive clock and data arrive as levels synchronous to the system clock. Data changes while the receive clock is low, and the block samples on the receive clock's rising edge.

Top module: `sync_word_detector`

## Requirements
- R1: With `bit_sync_i`=0 and `pat_sel_i`=0, the search word is 16'h9336, received MSB first (1001 0011 0011 0110). Any other 16-bit sequence does not set the flag.
- R2: With `bit_sync_i`=0 and `pat_sel_i`=1, the search word is 16'hC4D6, received MSB first (1100 0100 1101 0110).
- R3: With `bit_sync_i`=1, the search word is 20 bits: preamble 1010 followed with no gap by the selected 16-bit word (20'hA9336 or 20'hAC4D6). The frame word without the exact preamble does not set the flag.
- R4: While `det_en_i`=0, `frame_det_o` is 0, `rx_data_o` equals `rx_bit_i` and `rx_clk_o` equals `rx_clk_i`.
- R5: While `det_en_i`=1 and `frame_det_o`=0, `rx_data_o` and `rx_clk_o` are both 1.
- R6: `frame_det_o` rises on the first `clk_i` edge at which the rising `rx_clk_i` edge carrying the final word bit is seen. It is 1 one clock after `rx_clk_i` goes high for that bit.
- R7: Once set, `frame_det_o` stays 1 whatever bits follow, until `det_en_i` returns to 0 or a full power-down occurs.
- R8: After detection, both outputs stay high until the next falling `rx_clk_i` edge. From the cycle after that edge, they follow `rx_bit_i` and `rx_clk_i`, starting with the first bit after the word.
- R9: `pwr_dn_i`=1 with `rx_on_i`=0 clears `frame_det_o` on the next clock and holds it at 0. `pwr_dn_i`=1 with `rx_on_i`=1 has no effect on the flag.
- R10: Driving `det_en_i` to 0 discards all bits collected so far. After re-enabling, a word needs all of its bits received anew.
- R11: Exactly one bit is taken per rising `rx_clk_i` edge, however long `rx_clk_i` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_bit_i | input | 1 | Demodulated receive bit |
| rx_clk_i | input | 1 | Recovered receive clock level |
| det_en_i | input | 1 | Frame detector enable |
| bit_sync_i | input | 1 | Require 1010 preamble before the frame word |
| pat_sel_i | input | 1 | Frame word select: 0 = 9336h, 1 = C4D6h |
| pwr_dn_i | input | 1 | Power-down request |
| rx_on_i | input | 1 | Receive path enable |
| frame_det_o | output | 1 | Sticky frame-detect flag |
| rx_data_o | output | 1 | Gated receive data |
| rx_clk_o | output | 1 | Gated receive clock |

## Verification
The bench sends words that differ from the right one in one place: the other frame word, a preamble off by one bit, and a bare frame word with bit-sync on. A comparator that used the wrong width or the wrong word would flag these. Holding the receive clock high for many cycles exposes a design that shifts on the level rather than on the edge. A design of that kind fills the register with copies of one bit and misses the word. The bench disables the detector mid-word and exposes a design that keeps stale bits, because that design detects after one extra bit. It also checks the exact cycle of the gate release, which shows a design that opens the lines at the detecting edge and puts a glitch on the line while the clock is still high. A half power-down that clears the flag would also show up.

// File: rtl/fsd_pkg.sv
package fsd_pkg;
  localparam int unsigned FRAME_W  = 16;
  localparam int unsigned PRE_W    = 4;
  localparam logic [FRAME_W-1:0] WORD_A   = 16'h9336;
  localparam logic [FRAME_W-1:0] WORD_B   = 16'hC4D6;
  localparam logic [PRE_W-1:0]   PREAMBLE = 4'hA;
endpackage

// File: rtl/fsd_edge_det.sv
module fsd_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o,
  output logic fall_o
);
  logic prev_q;

  // idle-high line: reset to 1 so no false rise
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;
  assign fall_o = ~lvl_i & prev_q;
endmodule

// File: rtl/fsd_shift_match.sv
module fsd_shift_match #(
  parameter int unsigned FRAME_W = fsd_pkg::FRAME_W,
  parameter int unsigned PRE_W   = fsd_pkg::PRE_W,
  parameter logic [FRAME_W-1:0] WORD_A   = fsd_pkg::WORD_A,
  parameter logic [FRAME_W-1:0] WORD_B   = fsd_pkg::WORD_B,
  parameter logic [PRE_W-1:0]   PREAMBLE = fsd_pkg::PREAMBLE
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic shift_i,
  input  logic bit_i,
  input  logic bit_sync_i,
  input  logic pat_sel_i,
  output logic match_o
);
  localparam int unsigned SEARCH_W = FRAME_W + PRE_W;

  logic [SEARCH_W-1:0] sreg_q;
  logic [SEARCH_W-1:0] sreg_nxt;
  logic [FRAME_W-1:0]  word;
  logic [SEARCH_W-1:0] full_word;
  logic                hit;

  assign sreg_nxt  = {sreg_q[SEARCH_W-2:0], bit_i};
  assign word      = pat_sel_i ? WORD_B : WORD_A;
  assign full_word = {PREAMBLE, word};

  always_comb begin
    if (bit_sync_i) hit = (sreg_nxt == full_word);
    else            hit = (sreg_nxt[FRAME_W-1:0] == word);
  end

  // compare against the incoming bit so the flag sets on the same edge
  assign match_o = shift_i & hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sreg_q <= '0;
    else if (clr_i)   sreg_q <= '0;
    else if (shift_i) sreg_q <= sreg_nxt;
  end
endmodule

// File: rtl/fsd_gate_ctrl.sv
module fsd_gate_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic det_en_i,
  input  logic pd_full_i,
  input  logic match_i,
  input  logic fall_i,
  output logic det_o,
  output logic pass_o
);
  logic det_q, pass_q;
  logic kill;

  assign kill = ~det_en_i | pd_full_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      det_q <= 1'b0;
    else if (kill)    det_q <= 1'b0;
    else if (match_i) det_q <= 1'b1;
  end

  // open the lines on the falling rx edge after the sync word
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               pass_q <= 1'b0;
    else if (kill)             pass_q <= 1'b0;
    else if (det_q && fall_i)  pass_q <= 1'b1;
  end

  assign det_o  = det_q;
  assign pass_o = pass_q;

  a_r4_flag_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!det_en_i) |-> !det_q);
  a_r7_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (det_q && det_en_i && !pd_full_i) |=> det_q);
  a_r9_pd_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_full_i |=> !det_q);
  a_r8_pass_after_det: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pass_q |-> det_q);
  a_r6_set_on_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(det_q) |-> $past(match_i));
endmodule

// File: rtl/sync_word_detector.sv
module sync_word_detector #(
  parameter int unsigned FRAME_W = fsd_pkg::FRAME_W,
  parameter int unsigned PRE_W   = fsd_pkg::PRE_W,
  parameter logic [FRAME_W-1:0] WORD_A   = fsd_pkg::WORD_A,
  parameter logic [FRAME_W-1:0] WORD_B   = fsd_pkg::WORD_B,
  parameter logic [PRE_W-1:0]   PREAMBLE = fsd_pkg::PREAMBLE
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_bit_i,
  input  logic rx_clk_i,
  input  logic det_en_i,
  input  logic bit_sync_i,
  input  logic pat_sel_i,
  input  logic pwr_dn_i,
  input  logic rx_on_i,
  output logic frame_det_o,
  output logic rx_data_o,
  output logic rx_clk_o
);
  logic rise, fall, match, det, pass;
  logic pd_full, shift, clr, gate_open;

  assign pd_full = pwr_dn_i & ~rx_on_i;
  assign clr     = ~det_en_i | pd_full;
  assign shift   = rise & ~clr;

  fsd_edge_det u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (rx_clk_i),
    .rise_o (rise),
    .fall_o (fall)
  );

  fsd_shift_match #(
    .FRAME_W  (FRAME_W),
    .PRE_W    (PRE_W),
    .WORD_A   (WORD_A),
    .WORD_B   (WORD_B),
    .PREAMBLE (PREAMBLE)
  ) u_match (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (clr),
    .shift_i    (shift),
    .bit_i      (rx_bit_i),
    .bit_sync_i (bit_sync_i),
    .pat_sel_i  (pat_sel_i),
    .match_o    (match)
  );

  fsd_gate_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .det_en_i  (det_en_i),
    .pd_full_i (pd_full),
    .match_i   (match),
    .fall_i    (fall),
    .det_o     (det),
    .pass_o    (pass)
  );

  assign gate_open   = ~det_en_i | pass;
  assign rx_data_o   = gate_open ? rx_bit_i : 1'b1;
  assign rx_clk_o    = gate_open ? rx_clk_i : 1'b1;
  assign frame_det_o = det;

  a_r5_hold_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (det_en_i && !det) |-> (rx_data_o && rx_clk_o));
  a_r4_pass_thru: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !det_en_i |-> (rx_data_o == rx_bit_i && rx_clk_o == rx_clk_i));
endmodule

// File: tb/sim_sync_word_detector.sv
module sim_sync_word_detector;
  localparam int CLK_P = 10;

  typedef struct packed {
    logic        bs;
    logic        sel;
    logic [4:0]  n;
    logic [19:0] pat;
    logic        exp;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b0, 5'd16, 20'h09336, 1'b1},  // R1
    '{1'b0, 1'b1, 5'd16, 20'h0C4D6, 1'b1},  // R2
    '{1'b0, 1'b0, 5'd16, 20'h0C4D6, 1'b0},  // R1 wrong word
    '{1'b0, 1'b1, 5'd16, 20'h09336, 1'b0},  // R2 wrong word
    '{1'b1, 1'b0, 5'd20, 20'hA9336, 1'b1},  // R3
    '{1'b1, 1'b1, 5'd20, 20'hAC4D6, 1'b1},  // R3
    '{1'b1, 1'b0, 5'd16, 20'h09336, 1'b0},  // R3 no preamble
    '{1'b1, 1'b0, 5'd20, 20'hB9336, 1'b0},  // R3 bad preamble
    '{1'b1, 1'b1, 5'd20, 20'h2C4D6, 1'b0},  // R3 bad preamble
    '{1'b0, 1'b0, 5'd20, 20'hF9336, 1'b1}   // R1 leading junk
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_bit = 1'b1, rx_clk = 1'b1, det_en = 1'b0;
  logic bit_sync = 1'b0, pat_sel = 1'b0, pwr_dn = 1'b0, rx_on = 1'b1;
  logic frame_det, rx_data, rx_clk_g;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  sync_word_detector u0 (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .rx_bit_i    (rx_bit),
    .rx_clk_i    (rx_clk),
    .det_en_i    (det_en),
    .bit_sync_i  (bit_sync),
    .pat_sel_i   (pat_sel),
    .pwr_dn_i    (pwr_dn),
    .rx_on_i     (rx_on),
    .frame_det_o (frame_det),
    .rx_data_o   (rx_data),
    .rx_clk_o    (rx_clk_g)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // data changes with rx clock low; rising edge carries the bit
  task automatic send_bit(input logic b, input int hold);
    @(negedge clk); rx_clk = 1'b0; rx_bit = b;
    repeat (3) @(negedge clk);
    rx_clk = 1'b1;
    repeat (hold) @(negedge clk);
  endtask

  task automatic restart(input logic bs, input logic sel);
    @(negedge clk); det_en = 1'b0; bit_sync = bs; pat_sel = sel;
    repeat (2) @(negedge clk);
    det_en = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state / pass-through when disabled
    check("R4 reset flag", frame_det, 1'b0);
    rx_bit = 1'b0; rx_clk = 1'b0; #1;
    check("R4 data pass", rx_data, 1'b0);
    check("R4 clk pass", rx_clk_g, 1'b0);

    // vector table
    for (int v = 0; v < NV; v++) begin
      restart(VEC[v].bs, VEC[v].sel);
      for (int i = int'(VEC[v].n) - 1; i >= 0; i--) begin
        send_bit(VEC[v].pat[i], 3);
        if (i == 1) check("R5 no early flag", frame_det, 1'b0);
      end
      check($sformatf("R1/R2/R3 vec %0d", v), frame_det, VEC[v].exp);
      if (!VEC[v].exp) check("R5 held data", rx_data, 1'b1);
    end

    // R5 held high with low inputs
    restart(1'b0, 1'b0);
    @(negedge clk); rx_bit = 1'b0; rx_clk = 1'b0; #1;
    check("R5 data high", rx_data, 1'b1);
    check("R5 clk high", rx_clk_g, 1'b1);

    // R6 timing, R8 release, R7 sticky
    restart(1'b0, 1'b0);
    for (int i = 15; i >= 1; i--) send_bit(fsd_pkg::WORD_A[i], 3);
    @(negedge clk); rx_clk = 1'b0; rx_bit = 1'b0;
    repeat (3) @(negedge clk);
    check("R6 before last edge", frame_det, 1'b0);
    rx_clk = 1'b1;
    @(negedge clk);
    check("R6 one clock after", frame_det, 1'b1);
    check("R8 clk held until fall", rx_clk_g, 1'b1);
    check("R8 data held until fall", rx_data, 1'b1);
    rx_clk = 1'b0; rx_bit = 1'b0; #1;
    check("R8 still held pre-edge", rx_clk_g, 1'b1);
    @(negedge clk);
    check("R8 clk follows", rx_clk_g, 1'b0);
    check("R8 data follows", rx_data, 1'b0);
    for (int i = 0; i < 16; i++) send_bit(1'b0, 2);
    check("R7 sticky", frame_det, 1'b1);
    send_bit(1'b1, 2);
    check("R8 data passes 1", rx_data, 1'b1);

    // R9 power-down
    @(negedge clk); pwr_dn = 1'b1; rx_on = 1'b1;
    repeat (3) @(negedge clk);
    check("R9 partial pd no effect", frame_det, 1'b1);
    rx_on = 1'b0;
    @(negedge clk);
    check("R9 full pd clears", frame_det, 1'b0);
    rx_bit = 1'b0; #1;
    check("R9 lines held after pd", rx_data, 1'b1);
    @(negedge clk); pwr_dn = 1'b0; rx_on = 1'b1;
    repeat (3) @(negedge clk);
    check("R9 stays clear", frame_det, 1'b0);

    // R10 stale partial discarded
    restart(1'b0, 1'b0);
    for (int i = 15; i >= 1; i--) send_bit(fsd_pkg::WORD_A[i], 3);
    restart(1'b0, 1'b0);
    send_bit(1'b0, 3);
    check("R10 no stale detect", frame_det, 1'b0);
    for (int i = 15; i >= 0; i--) send_bit(fsd_pkg::WORD_A[i], 3);
    check("R10 fresh detect", frame_det, 1'b1);

    // R11 long high clock shifts one bit
    restart(1'b0, 1'b0);
    for (int i = 15; i >= 3; i--) send_bit(fsd_pkg::WORD_A[i], 3);
    send_bit(fsd_pkg::WORD_A[2], 50);
    send_bit(fsd_pkg::WORD_A[1], 3);
    send_bit(fsd_pkg::WORD_A[0], 3);
    check("R11 one bit per edge", frame_det, 1'b1);

    // R4 disable clears flag
    @(negedge clk); det_en = 1'b0;
    @(negedge clk);
    check("R4 disable clears", frame_det, 1'b0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule